// File: doc/BRIEF.md
# Transmit Byte Buffer with Collision Replay

This block sits between a host that writes outgoing frame data as 16-bit words and a serial transmit engine that takes it one byte at a time. The host marks the last word of each frame with an end-of-frame flag. That tag is stored beside the final byte so the transmit engine can see where the frame ends. A request output tells the host when enough room is free, measured against a programmable free-space watermark. A second output tells the transmit engine it may begin the preamble. It does so once a programmable number of bytes is buffered, or once a complete frame is present.

The bytes of the frame being sent are held in the buffer until 64 of them have gone out. Until then a collision can be answered by rewinding to the frame start, and the host does not have to supply the data again. If the engine gives up on a frame, the block discards the rest of that frame. It skips forward one byte per cycle until it has passed the stored end-of-frame tag. If no tag has been written yet, it empties the whole buffer at once.

The transmit engine's controls are taken in a fixed priority: abandon first, then frame complete, then rewind, then read.

Top module: `txRetryFifo`

## Requirements
- R1: After reset the buffer is empty. `macValid`, `dataReq`, `overflow` and `underflow` are all 0, and the effective watermark is `WMARK_DEFAULT`.
- R2: A host write stores the byte-enabled lanes in order. Lane 0 (bits 7:0, `hostByteEn[0]`) is stored before lane 1 (bits 15:8, `hostByteEn[1]`). When `hostEof` is set, the end tag goes on the last stored byte of that word. `macByte` and `macLast` show the oldest unread byte and its tag.
- R3: The buffer holds `DEPTH` bytes, counting the retained ones. A write whose enabled byte count exceeds the free space is dropped whole and sets `overflow`, which stays set until reset.
- R4: `macRd` with `macValid` high advances to the next byte. `macRd` while nothing is readable changes nothing and sets `underflow`, which stays set until reset.
- R5: `txGo` is high, except during a discard, when the unread byte count is at least `startPoint` or at least one complete tagged frame is stored.
- R6: `macRewind` while fewer than `WINDOW` bytes of the current frame have been read makes the frame's first byte the head again. All bytes read since then become readable again.
- R7: Once `WINDOW` bytes of the current frame have been read, those bytes are freed and `macRewind` has no effect.
- R8: `macDone` retires the current frame. Its retained bytes are freed and the next byte becomes the start of the next frame.
- R9: `macAbort` while the current frame's tag is still unread starts a discard. Each cycle one byte is dropped, while a byte is available, and the discard ends after the tagged byte. `macValid` and `txGo` are low during it. If the tag has already been read, `macAbort` retires the frame like `macDone`.
- R10: `macAbort` when no tagged frame is stored empties the buffer in one cycle. A host write in that cycle is dropped. The watermark is reloaded from `wmarkIn`.
- R11: `dataReq` rises one cycle after the free space is at least the effective watermark. Once high it stays high for at least `HOLD` cycles.
- R12: A change on `wmarkIn` takes effect only on a cycle with `wmarkLoad` high, or on an emptying abandon (R10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe |
| hostData | input | 16 | Host write word |
| hostByteEn | input | 2 | Lane enables, bit 0 for bits 7:0 |
| hostEof | input | 1 | Word ends the frame |
| wmarkIn | input | CNT_W | Requested free-space watermark in bytes |
| wmarkLoad | input | 1 | Apply `wmarkIn` |
| startPoint | input | CNT_W | Buffered byte count that allows transmission |
| dataReq | output | 1 | Request for more host data |
| txGo | output | 1 | Transmit engine may start |
| macRd | input | 1 | Take the head byte |
| macRewind | input | 1 | Replay the frame after a collision |
| macDone | input | 1 | Frame sent successfully |
| macAbort | input | 1 | Abandon the current frame |
| macValid | output | 1 | Head byte is readable |
| macByte | output | 8 | Head byte |
| macLast | output | 1 | Head byte ends its frame |
| overflow | output | 1 | Sticky dropped-write flag |
| underflow | output | 1 | Sticky empty-read flag |

## Verification
Some properties are checked on every cycle:
- the stored plus retained byte count never exceeds the capacity;
- a committed frame keeps no retained bytes;
- a discard only ends just after a tagged byte;
- the frame-start pointer lines up with the read pointer whenever it is resynchronised;
- the request line never falls while its hold count is running.

Other properties only show up in the bench's scenarios. These are the byte order across the byte-enable patterns, the replay returning the same first byte, the rewind being refused after 64 bytes, the discard landing exactly on the next frame, and the watermark staying ignored until it is loaded. Each of these is compared against a queue-based model on every clock.

// File: rtl/txfifo_pkg.sv
package txfifo_pkg;
  typedef struct packed {
    logic wrLo;     // store lane 0 byte
    logic wrHi;     // store lane 1 byte
    logic wrEof;    // tag the last stored byte
    logic rdStep;   // advance read pointer
    logic rewind;   // read pointer back to frame start
    logic syncSof;  // frame start follows the next read pointer
    logic clear;    // empty everything
  } fifoStrobes_t;
endpackage

// File: rtl/txfifo_dp.sv
module txfifo_dp
  import txfifo_pkg::*;
#(
  parameter int DEPTH = 136,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rstN,
  input  fifoStrobes_t strobes,
  input  logic [15:0]  wrData,
  output logic [7:0]   headByte,
  output logic         headEof
);
  typedef logic [PTR_W-1:0] ptr_t;

  function automatic ptr_t bump(ptr_t p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [8:0] mem [DEPTH];
  ptr_t wrPtr, rdPtr, sofPtr;
  ptr_t wrPtr1, wrPtr2, rdNext;

  assign wrPtr1 = bump(wrPtr);
  assign wrPtr2 = bump(wrPtr1);
  assign rdNext = strobes.rewind ? sofPtr : (strobes.rdStep ? bump(rdPtr) : rdPtr);

  always_ff @(posedge clk) begin
    if (strobes.wrLo && strobes.wrHi) begin
      mem[wrPtr]  <= {1'b0, wrData[7:0]};
      mem[wrPtr1] <= {strobes.wrEof, wrData[15:8]};
    end else if (strobes.wrLo) begin
      mem[wrPtr] <= {strobes.wrEof, wrData[7:0]};
    end else if (strobes.wrHi) begin
      mem[wrPtr] <= {strobes.wrEof, wrData[15:8]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clear) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      sofPtr <= '0;
    end else begin
      if (strobes.wrLo && strobes.wrHi)       wrPtr <= wrPtr2;
      else if (strobes.wrLo || strobes.wrHi)  wrPtr <= wrPtr1;
      rdPtr <= rdNext;
      if (strobes.syncSof) sofPtr <= rdNext;
    end
  end

  assign headByte = mem[rdPtr][7:0];
  assign headEof  = mem[rdPtr][8];

  // R8: a resynchronised frame start lands on the read position
  a_r8_sof_follows_read: assert property (@(posedge clk) disable iff (!rstN)
    strobes.syncSof && !strobes.clear |=> sofPtr == rdPtr);
endmodule

// File: rtl/txfifo_ctrl.sv
module txfifo_ctrl
  import txfifo_pkg::*;
#(
  parameter int DEPTH = 136,
  parameter int WINDOW = 64,
  parameter int HOLD = 4,
  parameter int WMARK_DEFAULT = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int WIN_W = $clog2(WINDOW + 1),
  localparam int HOLD_W = $clog2(HOLD + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWrEn,
  input  logic [1:0]       hostByteEn,
  input  logic             hostEof,
  input  logic [CNT_W-1:0] wmarkIn,
  input  logic             wmarkLoad,
  input  logic [CNT_W-1:0] startPoint,
  input  logic             macRd,
  input  logic             macRewind,
  input  logic             macDone,
  input  logic             macAbort,
  input  logic             headEof,
  output fifoStrobes_t     strobes,
  output logic             macValid,
  output logic             txGo,
  output logic             dataReq,
  output logic             overflow,
  output logic             underflow
);
  localparam logic [CNT_W-1:0]  DEPTH_C = CNT_W'(DEPTH);
  localparam logic [WIN_W-1:0]  WIN_MAX = WIN_W'(WINDOW);
  localparam logic [WIN_W-1:0]  WIN_PRE = WIN_W'(WINDOW - 1);
  localparam logic [HOLD_W-1:0] HOLD_INIT = HOLD_W'(HOLD - 1);

  logic [CNT_W-1:0]  avail, retCnt, eofCnt, wmEff;
  logic [CNT_W-1:0]  availN, retN, eofN;
  logic [WIN_W-1:0]  sentCnt, sentN;
  logic [HOLD_W-1:0] holdCnt;
  logic eofRead, eofReadN, flushing, flushN;
  logic [CNT_W-1:0] nWr, used, freeSpace;
  logic wantWr, wrOk, clearNow, availSub, eofDec, udfSet, reqCond;

  assign nWr       = CNT_W'(hostByteEn[0]) + CNT_W'(hostByteEn[1]);
  assign used      = avail + retCnt;
  assign freeSpace = DEPTH_C - used;
  assign wantWr    = hostWrEn && (hostByteEn != 2'b00);
  assign wrOk      = wantWr && (freeSpace >= nWr);
  assign clearNow  = macAbort && !flushing && (eofCnt == '0);
  assign reqCond   = freeSpace >= wmEff;

  always_comb begin
    strobes  = '0;
    availN   = avail;
    retN     = retCnt;
    sentN    = sentCnt;
    eofN     = eofCnt;
    eofReadN = eofRead;
    flushN   = flushing;
    availSub = 1'b0;
    eofDec   = 1'b0;
    udfSet   = 1'b0;
    if (clearNow) begin
      strobes.clear = 1'b1;
      availN   = '0;
      retN     = '0;
      sentN    = '0;
      eofN     = '0;
      eofReadN = 1'b0;
      flushN   = 1'b0;
    end else begin
      strobes.wrLo  = wrOk && hostByteEn[0];
      strobes.wrHi  = wrOk && hostByteEn[1];
      strobes.wrEof = hostEof;
      if (flushing) begin
        if (avail != '0) begin
          strobes.rdStep  = 1'b1;
          strobes.syncSof = 1'b1;
          availSub = 1'b1;
          if (headEof) begin
            flushN = 1'b0;
            eofDec = 1'b1;
          end
        end
      end else if (macAbort) begin
        strobes.syncSof = 1'b1;
        retN     = '0;
        sentN    = '0;
        eofReadN = 1'b0;
        if (eofRead) eofDec = 1'b1;
        else         flushN = 1'b1;
      end else if (macDone) begin
        strobes.syncSof = 1'b1;
        retN     = '0;
        sentN    = '0;
        eofReadN = 1'b0;
        eofDec   = eofRead;
      end else if (macRewind) begin
        if (sentCnt < WIN_MAX) begin
          strobes.rewind = 1'b1;
          retN     = '0;
          sentN    = '0;
          eofReadN = 1'b0;
        end
      end else if (macRd) begin
        if (avail != '0) begin
          strobes.rdStep = 1'b1;
          availSub = 1'b1;
          if (sentCnt >= WIN_PRE) begin
            sentN = WIN_MAX;
            strobes.syncSof = 1'b1;
            retN = '0;
          end else begin
            sentN = sentCnt + 1'b1;
            retN  = retCnt + 1'b1;
          end
          if (headEof) eofReadN = 1'b1;
        end else begin
          udfSet = 1'b1;
        end
      end
      availN = avail + (wrOk ? nWr : '0) - CNT_W'(availSub)
               + (strobes.rewind ? retCnt : '0);
      eofN = eofCnt + CNT_W'(wrOk && hostEof) - CNT_W'(eofDec);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      avail     <= '0;
      retCnt    <= '0;
      sentCnt   <= '0;
      eofCnt    <= '0;
      eofRead   <= 1'b0;
      flushing  <= 1'b0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
      wmEff     <= CNT_W'(WMARK_DEFAULT);
      dataReq   <= 1'b0;
      holdCnt   <= '0;
    end else begin
      avail    <= availN;
      retCnt   <= retN;
      sentCnt  <= sentN;
      eofCnt   <= eofN;
      eofRead  <= eofReadN;
      flushing <= flushN;
      if (wantWr && !wrOk && !clearNow) overflow <= 1'b1;
      if (wantWr && (freeSpace < nWr))  overflow <= 1'b1;
      if (udfSet) underflow <= 1'b1;
      if (clearNow || wmarkLoad) wmEff <= wmarkIn;
      if (!dataReq) begin
        dataReq <= reqCond;
        holdCnt <= HOLD_INIT;
      end else if (holdCnt != '0) begin
        holdCnt <= holdCnt - 1'b1;
      end else begin
        dataReq <= reqCond;
      end
    end
  end

  assign macValid = !flushing && (avail != '0);
  assign txGo     = !flushing && ((eofCnt != '0) || (avail >= startPoint));

  // R3: stored plus retained bytes never exceed capacity
  a_r3_used_bounded: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, avail} + {1'b0, retCnt}) <= (CNT_W + 1)'(DEPTH));
  // R4: underflow only rises after an empty cycle
  a_r4_udf_only_empty: assert property (@(posedge clk) disable iff (!rstN)
    $rose(underflow) |-> $past(avail) == '0);
  // R6: an accepted rewind leaves nothing retained
  a_r6_rewind_resets: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rewind |=> retCnt == '0 && sentCnt == '0);
  // R7: a committed frame holds no retained bytes
  a_r7_commit_releases: assert property (@(posedge clk) disable iff (!rstN)
    sentCnt == WIN_MAX |-> retCnt == '0);
  // R9: a discard ends only after a tagged byte
  a_r9_flush_ends_on_tag: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flushing) |-> $past(headEof));
  // R11: the request never drops inside its hold time
  a_r11_min_hold: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataReq) |-> $past(holdCnt) == '0);
endmodule

// File: rtl/txRetryFifo.sv
module txRetryFifo
  import txfifo_pkg::*;
#(
  parameter int DEPTH = 136,
  parameter int WINDOW = 64,
  parameter int HOLD = 4,
  parameter int WMARK_DEFAULT = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWrEn,
  input  logic [15:0]      hostData,
  input  logic [1:0]       hostByteEn,
  input  logic             hostEof,
  input  logic [CNT_W-1:0] wmarkIn,
  input  logic             wmarkLoad,
  input  logic [CNT_W-1:0] startPoint,
  output logic             dataReq,
  output logic             txGo,
  input  logic             macRd,
  input  logic             macRewind,
  input  logic             macDone,
  input  logic             macAbort,
  output logic             macValid,
  output logic [7:0]       macByte,
  output logic             macLast,
  output logic             overflow,
  output logic             underflow
);
  fifoStrobes_t strobes;
  logic headEof;

  txfifo_ctrl #(
    .DEPTH(DEPTH), .WINDOW(WINDOW), .HOLD(HOLD), .WMARK_DEFAULT(WMARK_DEFAULT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .hostWrEn(hostWrEn), .hostByteEn(hostByteEn), .hostEof(hostEof),
    .wmarkIn(wmarkIn), .wmarkLoad(wmarkLoad), .startPoint(startPoint),
    .macRd(macRd), .macRewind(macRewind), .macDone(macDone), .macAbort(macAbort),
    .headEof(headEof), .strobes(strobes),
    .macValid(macValid), .txGo(txGo), .dataReq(dataReq),
    .overflow(overflow), .underflow(underflow)
  );

  txfifo_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(hostData),
    .headByte(macByte), .headEof(headEof)
  );

  assign macLast = macValid && headEof;
endmodule

// File: tb/txRetryFifo_bench.sv
module txRetryFifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 136;
  localparam int WINDOW = 64;
  localparam int HOLD = 4;
  localparam int WMARK_DEFAULT = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWrEn = 1'b0, hostEof = 1'b0, wmarkLoad = 1'b0;
  logic [15:0] hostData = '0;
  logic [1:0] hostByteEn = '0;
  logic [CNT_W-1:0] wmarkIn = CNT_W'(WMARK_DEFAULT);
  logic [CNT_W-1:0] startPoint = CNT_W'(8);
  logic macRd = 1'b0, macRewind = 1'b0, macDone = 1'b0, macAbort = 1'b0;
  logic dataReq, txGo, macValid, macLast, overflow, underflow;
  logic [7:0] macByte;

  always #(CLK_PERIOD / 2) clk = ~clk;

  txRetryFifo #(.DEPTH(DEPTH), .WINDOW(WINDOW), .HOLD(HOLD), .WMARK_DEFAULT(WMARK_DEFAULT))
  u_txRetryFifo (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostData(hostData),
    .hostByteEn(hostByteEn), .hostEof(hostEof), .wmarkIn(wmarkIn),
    .wmarkLoad(wmarkLoad), .startPoint(startPoint), .dataReq(dataReq), .txGo(txGo),
    .macRd(macRd), .macRewind(macRewind), .macDone(macDone), .macAbort(macAbort),
    .macValid(macValid), .macByte(macByte), .macLast(macLast),
    .overflow(overflow), .underflow(underflow)
  );

  int nChecks = 0, nFails = 0, cycles = 0, reqRun = 0;

  // behavioural reference: queue holds bytes from frame start to write end
  int q[$];
  int mRd = 0, mSent = 0, mEofCnt = 0, mHold = 0, mWm = WMARK_DEFAULT;
  bit mFlush = 0, mEofRead = 0, mOvf = 0, mUdf = 0, mDq = 0;

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  task automatic chk(bit ok, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  function automatic int availM();
    return q.size() - mRd;
  endfunction

  task automatic compare();
    bit expValid, expLast, expGo, bad;
    int expByte;
    bad = 0;
    expValid = !mFlush && availM() > 0;
    expByte  = expValid ? (q[mRd] & 255) : 0;
    expLast  = expValid && ((q[mRd] >> 8) != 0);
    expGo    = !mFlush && (mEofCnt > 0 || availM() >= int'(startPoint));
    nChecks++;
    if (macValid !== expValid) begin bad = 1; $display("FAIL R4 macValid act=%0d exp=%0d", macValid, expValid); end
    if (expValid && macByte !== 8'(expByte)) begin bad = 1; $display("FAIL R2 macByte act=%0d exp=%0d", macByte, expByte); end
    if (macLast !== expLast) begin bad = 1; $display("FAIL R2 macLast act=%0d exp=%0d", macLast, expLast); end
    if (txGo !== expGo) begin bad = 1; $display("FAIL R5 txGo act=%0d exp=%0d", txGo, expGo); end
    if (dataReq !== mDq) begin bad = 1; $display("FAIL R11 dataReq act=%0d exp=%0d", dataReq, mDq); end
    if (overflow !== mOvf) begin bad = 1; $display("FAIL R3 overflow act=%0d exp=%0d", overflow, mOvf); end
    if (underflow !== mUdf) begin bad = 1; $display("FAIL R4 underflow act=%0d exp=%0d", underflow, mUdf); end
    if (bad) nFails++;
  endtask

  task automatic modelStep();
    int freeP, availP, n, e;
    bit ok, clr;
    freeP  = DEPTH - q.size();
    availP = availM();
    if (!mDq) begin mDq = (freeP >= mWm); mHold = HOLD - 1; end
    else if (mHold > 0) mHold--;
    else mDq = (freeP >= mWm);
    n   = int'(hostByteEn[0]) + int'(hostByteEn[1]);
    ok  = hostWrEn && n > 0 && freeP >= n;
    if (hostWrEn && n > 0 && freeP < n) mOvf = 1;
    clr = macAbort && !mFlush && mEofCnt == 0;
    if (clr) begin
      q.delete(); mRd = 0; mSent = 0; mEofCnt = 0; mEofRead = 0; mFlush = 0;
      mWm = int'(wmarkIn);
      return;
    end
    if (wmarkLoad) mWm = int'(wmarkIn);
    if (mFlush) begin
      if (availP > 0) begin
        e = q.pop_front();
        if ((e >> 8) != 0) begin mFlush = 0; mEofCnt--; end
      end
    end else if (macAbort) begin
      repeat (mRd) void'(q.pop_front());
      mRd = 0; mSent = 0;
      if (mEofRead) mEofCnt--; else mFlush = 1;
      mEofRead = 0;
    end else if (macDone) begin
      repeat (mRd) void'(q.pop_front());
      mRd = 0; mSent = 0;
      if (mEofRead) mEofCnt--;
      mEofRead = 0;
    end else if (macRewind) begin
      if (mSent < WINDOW) begin mRd = 0; mSent = 0; mEofRead = 0; end
    end else if (macRd) begin
      if (availP > 0) begin
        e = q[mRd];
        mSent = (mSent + 1 > WINDOW) ? WINDOW : mSent + 1;
        if (mSent == WINDOW) begin repeat (mRd + 1) void'(q.pop_front()); mRd = 0; end
        else mRd++;
        if ((e >> 8) != 0) mEofRead = 1;
      end else mUdf = 1;
    end
    if (ok) begin
      if (hostByteEn[0]) q.push_back(int'(hostData[7:0]) | ((hostEof && !hostByteEn[1]) ? 256 : 0));
      if (hostByteEn[1]) q.push_back(int'(hostData[15:8]) | (hostEof ? 256 : 0));
      if (hostEof) mEofCnt++;
    end
  endtask

  task automatic cyc();
    #1;
    compare();
    if (dataReq) reqRun++;
    else begin
      if (reqRun > 0) chk(reqRun >= HOLD, "R11 dataReq high run", reqRun, HOLD);
      reqRun = 0;
    end
    @(posedge clk);
    modelStep();
    @(negedge clk);
    hostWrEn = 0; hostEof = 0; hostByteEn = 2'b00; wmarkLoad = 0;
    macRd = 0; macRewind = 0; macDone = 0; macAbort = 0;
    cycles++;
    if (cycles > WATCHDOG) begin
      nChecks++; nFails++;
      $display("FAIL R1 watchdog act=%0d exp<%0d", cycles, WATCHDOG);
      finishRun();
    end
  endtask

  task automatic wrWord(logic [15:0] d, logic [1:0] be, logic eof);
    hostWrEn = 1; hostData = d; hostByteEn = be; hostEof = eof;
    cyc();
  endtask

  task automatic writeFrame(int seed, int nWords, bit withEof);
    for (int k = 0; k < nWords; k++)
      wrWord({8'(seed + 2 * k + 1), 8'(seed + 2 * k)}, 2'b11, withEof && k == nWords - 1);
  endtask

  task automatic readN(int n);
    repeat (n) begin macRd = 1; cyc(); end
  endtask

  task automatic idle(int n);
    repeat (n) cyc();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    #1;
    chk(!dataReq && !macValid && !overflow && !underflow, "R1 reset outputs",
        {dataReq, macValid, overflow, underflow}, 0);

    // frame A: 10 bytes, start point 8
    writeFrame(8'h10, 3, 0);
    chk(txGo == 0, "R5 below start point", txGo, 0);
    wrWord({8'h17, 8'h16}, 2'b11, 0);
    chk(txGo == 1, "R5 start point reached", txGo, 1);
    wrWord({8'h19, 8'h18}, 2'b11, 1);
    chk(macByte == 8'h10, "R2 low lane first", macByte, 8'h10);
    readN(10);
    macDone = 1; cyc();
    chk(txGo == 0 && macValid == 0, "R8 retired frame leaves buffer empty", {txGo, macValid}, 0);

    // frame B: mixed byte enables
    wrWord(16'h2120, 2'b11, 0);
    wrWord(16'h2322, 2'b01, 0);
    wrWord(16'h2524, 2'b10, 0);
    wrWord(16'h2726, 2'b01, 1);
    readN(3);
    chk(macByte == 8'h25, "R2 high-only lane stored", macByte, 8'h25);
    readN(1);
    chk(macLast == 1 && macByte == 8'h26, "R2 tag on last stored lane", {macLast, macByte}, 9'h126);
    readN(1);
    macDone = 1; cyc();

    // retry: 80-byte frame
    writeFrame(8'h40, 40, 1);
    readN(30);
    macRewind = 1; cyc();
    chk(macByte == 8'h40, "R6 rewind replays frame start", macByte, 8'h40);
    readN(70);
    macRewind = 1; cyc();
    chk(macByte == 8'(8'h40 + 70), "R7 rewind ignored after window", macByte, 8'h40 + 70);
    readN(10);
    macDone = 1; cyc();

    // discard: frame C then frame D
    writeFrame(8'h80, 6, 1);
    writeFrame(8'hA0, 3, 1);
    readN(3);
    macAbort = 1; cyc();
    chk(macValid == 0 && txGo == 0, "R9 discard hides head", {macValid, txGo}, 0);
    idle(12);
    chk(macValid == 1 && macByte == 8'hA0, "R9 discard lands on next frame", macByte, 8'hA0);
    readN(6);
    macDone = 1; cyc();

    // abandon after tag read retires the frame
    writeFrame(8'hC0, 2, 1);
    readN(4);
    macAbort = 1; cyc();
    chk(txGo == 0 && macValid == 0, "R9 abandon after tag retires", {txGo, macValid}, 0);

    // emptying abandon with no tag
    wmarkIn = CNT_W'(40);
    writeFrame(8'hD0, 3, 0);
    macAbort = 1; cyc();
    chk(macValid == 0 && txGo == 0, "R10 untagged abandon empties", {macValid, txGo}, 0);

    // watermark staging: 20 bytes held, free 116
    writeFrame(8'hE0, 10, 0);
    wmarkIn = CNT_W'(120);
    idle(6);
    chk(dataReq == 1, "R12 unloaded watermark ignored", dataReq, 1);
    wmarkLoad = 1; cyc();
    idle(1);
    chk(dataReq == 0, "R12 loaded watermark applied", dataReq, 0);
    wmarkIn = CNT_W'(WMARK_DEFAULT);
    macAbort = 1; cyc();
    idle(HOLD + 2);

    // overflow: 138 bytes offered
    writeFrame(8'h01, 69, 0);
    chk(overflow == 1, "R3 write past capacity dropped", overflow, 1);
    chk(overflow == 1 && txGo == 1, "R3 capacity filled", txGo, 1);
    macAbort = 1; cyc();

    // underflow
    macRd = 1; cyc();
    chk(underflow == 1 && macValid == 0, "R4 empty read flagged", underflow, 1);
    idle(HOLD + 2);

    finishRun();
  end
endmodule